// File: doc/BRIEF.md
# Isochronous Timestamp Offset Adder

This block produces the transmit timestamp for isochronous packets. Each of eight transmit contexts has its own programmable offset. The block adds the offset of the selected context to a free-running bus cycle timer. The timer carries three fields: a seconds count, a cycle count that wraps at 8000 and a sub-cycle offset that wraps at 3072. Only the two low fields reach the output.

The addition is mixed-radix. The sub-cycle field is summed modulo 3072, and any overflow carries into the cycle-count sum, which is taken modulo 8000. Offsets apply only when the selected context runs in a video-stream mode:

- **DV mode** always adds the offset.
- **MPEG2 mode** adds the offset too, except that a per-context flag can suppress it on the first packet, which is marked by an initial-packet strobe.
- **Any other mode** passes the timer through unchanged.

Software programs the offsets through a simple word-addressed register port. The adjusted timestamp is registered, so it appears one clock after its inputs.

Top module: `ts_offset_adder`

## Requirements
- R1: While `rst_n` is low, every offset register reads 0 and `ts_out` is 0.
- R2: Word index `reg_addr` = n (0 to 7) selects the offset register of context n. A write with `reg_we` high stores into that register only, and the next read of index n returns the stored value.
- R3: Register layout: bit 31 is the skip-initial flag, bits 24:12 are the cycle-count offset and bits 11:0 are the sub-cycle offset. Bits 30:25 always read 0 and ignore writes.
- R4: `mode` encoding: 0 is pass-through, 1 is DV, 2 is MPEG2 and 3 is pass-through. In a pass-through mode, `ts_out` equals `cyc_timer[24:0]` one clock later.
- R5: The output sub-cycle field `ts_out[11:0]` is the timer field `cyc_timer[11:0]` plus the context's sub-cycle offset. When that sum is 3072 or more, 3072 is subtracted and a carry of 1 goes into the cycle-count sum.
- R6: The output cycle field `ts_out[24:12]` is the timer field `cyc_timer[24:12]` plus the context's cycle-count offset plus that carry. When the total is 8000 or more, 8000 is subtracted.
- R7: When both fields wrap in the same cycle, both are reduced correctly, including sums exactly equal to 3072 and 8000.
- R8: In DV mode the skip-initial flag has no effect, even when `init_pkt` is high.
- R9: In MPEG2 mode, with the flag set and `init_pkt` high, the offset is not added and the timer passes through. With `init_pkt` low, or with the flag clear, the offset is added.
- R10: `ctx_sel` picks which context's offset is used. The result appears on `ts_out` at the first rising clock edge after the inputs are presented, and not before it.
- R11: The seconds field `cyc_timer[31:25]` has no effect on `ts_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index (context number) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| ctx_sel | input | 3 | Context whose offset is applied |
| mode | input | 2 | 0 pass, 1 DV, 2 MPEG2, 3 pass |
| init_pkt | input | 1 | Marks the initial packet of a stream |
| cyc_timer | input | 32 | Cycle timer: seconds[31:25], cycle[24:12], sub-cycle[11:0] |
| ts_out | output | 25 | Adjusted timestamp: cycle[24:12], sub-cycle[11:0] |

## Verification
The bench targets the sub-cycle sums that land on exactly 3072 and one below it. A design with an off-by-one compare would either leave an illegal 3072 on the output or drop a carry that was owed. It also targets cycle sums that reach 8000 only because of the incoming carry. A design that compared before adding the carry would emit 8000 or lose a wrap. The skip-initial flag is checked in both modes and with the strobe both high and low: a design that ignored the mode or the strobe would drop offsets on ordinary packets, or drop them in DV mode. Further checks confirm that the reserved bits stay zero and that the seconds field cannot leak into the result.

// File: rtl/ts_pkg.sv
package ts_pkg;
  localparam int SEC_W   = 7;
  localparam int CNT_W   = 13;
  localparam int OFS_W   = 12;
  localparam int CNT_MOD = 8000;
  localparam int OFS_MOD = 3072;
  localparam int TS_W    = CNT_W + OFS_W;
  localparam int WORD_W  = 32;
  localparam int SKIP_BIT = WORD_W - 1;

  typedef enum logic [1:0] {
    MODE_PASS = 2'd0,
    MODE_DV   = 2'd1,
    MODE_MPEG = 2'd2,
    MODE_RSV  = 2'd3
  } mode_e;

  typedef struct packed {
    logic             skip_init;
    logic [CNT_W-1:0] cnt;
    logic [OFS_W-1:0] ofs;
  } ofs_entry_t;

  function automatic ofs_entry_t word_to_entry(input logic [WORD_W-1:0] w);
    ofs_entry_t e;
    e.skip_init = w[SKIP_BIT];
    e.cnt       = w[OFS_W +: CNT_W];
    e.ofs       = w[OFS_W-1:0];
    return e;
  endfunction

  function automatic logic [WORD_W-1:0] entry_to_word(input ofs_entry_t e);
    logic [WORD_W-1:0] w;
    w                 = '0;
    w[SKIP_BIT]       = e.skip_init;
    w[OFS_W +: CNT_W] = e.cnt;
    w[OFS_W-1:0]      = e.ofs;
    return w;
  endfunction
endpackage

// File: rtl/ts_mod_add.sv
module ts_mod_add #(
  parameter int W   = 12,
  parameter int MOD = 3072
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  localparam int SW = W + 1;
  localparam logic [SW-1:0] MOD_V = SW'(MOD);

  logic [SW-1:0] raw;
  logic [SW-1:0] red;

  always_comb begin
    raw  = SW'(a) + SW'(b) + SW'(cin);
    cout = (raw >= MOD_V);
    red  = cout ? (raw - MOD_V) : raw;
    sum  = red[W-1:0];
  end
endmodule

// File: rtl/ts_ofs_regfile.sv
module ts_ofs_regfile
  import ts_pkg::*;
#(
  parameter int NUM_CTX = 8,
  parameter int AW      = $clog2(NUM_CTX)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_idx,
  input  logic [WORD_W-1:0] wr_word,
  input  logic [AW-1:0]     rd_idx,
  output logic [WORD_W-1:0] rd_word,
  input  logic [AW-1:0]     sel_idx,
  output ofs_entry_t        sel_entry
);
  ofs_entry_t         q_entry [NUM_CTX];
  ofs_entry_t         d_entry;
  logic [NUM_CTX-1:0] ce;

  assign d_entry = word_to_entry(wr_word);

  for (genvar g = 0; g < NUM_CTX; g++) begin : g_ctx
    assign ce[g] = wr_en && (wr_idx == AW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q_entry[g] <= '0;
      end else if (ce[g]) begin
        q_entry[g] <= d_entry;
      end
    end
  end

  assign rd_word   = entry_to_word(q_entry[rd_idx]);
  assign sel_entry = q_entry[sel_idx];
endmodule

// File: rtl/ts_offset_adder.sv
module ts_offset_adder
  import ts_pkg::*;
#(
  parameter int NUM_CTX = 8,
  parameter int AW      = $clog2(NUM_CTX)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [AW-1:0]     reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  input  logic [AW-1:0]     ctx_sel,
  input  logic [1:0]        mode,
  input  logic              init_pkt,
  input  logic [WORD_W-1:0] cyc_timer,
  output logic [TS_W-1:0]   ts_out
);
  ofs_entry_t       sel_entry;
  logic [CNT_W-1:0] tm_cnt;
  logic [OFS_W-1:0] tm_ofs;
  logic             unused_sec;
  logic             apply_ofs;
  logic [CNT_W-1:0] add_cnt;
  logic [OFS_W-1:0] add_ofs;
  logic [CNT_W-1:0] sum_cnt;
  logic [OFS_W-1:0] sum_ofs;
  logic             ofs_carry;
  logic             cnt_wrap_unused;
  logic [TS_W-1:0]  ts_d;
  logic [TS_W-1:0]  ts_q;
  mode_e            mode_q;

  ts_ofs_regfile #(.NUM_CTX(NUM_CTX), .AW(AW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (reg_we),
    .wr_idx   (reg_addr),
    .wr_word  (reg_wdata),
    .rd_idx   (reg_addr),
    .rd_word  (reg_rdata),
    .sel_idx  (ctx_sel),
    .sel_entry(sel_entry)
  );

  assign tm_ofs     = cyc_timer[OFS_W-1:0];
  assign tm_cnt     = cyc_timer[OFS_W +: CNT_W];
  assign unused_sec = ^cyc_timer[WORD_W-1:TS_W];
  assign mode_q     = mode_e'(mode);

  always_comb begin
    unique case (mode_q)
      MODE_DV:   apply_ofs = 1'b1;
      MODE_MPEG: apply_ofs = !(init_pkt && sel_entry.skip_init);
      default:   apply_ofs = 1'b0;
    endcase
    add_cnt = apply_ofs ? sel_entry.cnt : '0;
    add_ofs = apply_ofs ? sel_entry.ofs : '0;
  end

  ts_mod_add #(.W(OFS_W), .MOD(OFS_MOD)) u_add_ofs (
    .a   (tm_ofs),
    .b   (add_ofs),
    .cin (1'b0),
    .sum (sum_ofs),
    .cout(ofs_carry)
  );

  ts_mod_add #(.W(CNT_W), .MOD(CNT_MOD)) u_add_cnt (
    .a   (tm_cnt),
    .b   (add_cnt),
    .cin (ofs_carry),
    .sum (sum_cnt),
    .cout(cnt_wrap_unused)
  );

  assign ts_d = {sum_cnt, sum_ofs};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ts_q <= '0;
    end else begin
      ts_q <= ts_d;
    end
  end

  assign ts_out = ts_q;
endmodule

// File: rtl/ts_offset_chk.sv
module ts_offset_chk
  import ts_pkg::*;
#(
  parameter int AW = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [AW-1:0]     reg_addr,
  input logic [WORD_W-1:0] reg_wdata,
  input logic [WORD_W-1:0] reg_rdata,
  input logic [1:0]        mode,
  input logic [WORD_W-1:0] cyc_timer,
  input logic [TS_W-1:0]   ts_out
);
  localparam logic [WORD_W-1:0] KEEP_MASK = 32'h81FF_FFFF;

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (rst_n || (ts_out == '0 && reg_rdata == '0)));

  assert_wr_rd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> (!$stable(reg_addr) || reg_rdata == ($past(reg_wdata) & KEEP_MASK)));

  assert_rsv_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[30:25] == 6'b0);

  assert_passthru_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 || mode == 2'd3) |=> ts_out == $past(cyc_timer[TS_W-1:0]));

  assert_fields_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 || mode == 2'd3 ||
     (cyc_timer[OFS_W-1:0] < OFS_W'(OFS_MOD) && cyc_timer[TS_W-1:OFS_W] < CNT_W'(CNT_MOD)))
    |=> (ts_out[OFS_W-1:0] < OFS_W'(OFS_MOD) || $past(mode) != 2'd1));
endmodule

bind ts_offset_adder ts_offset_chk #(.AW(AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_we   (reg_we),
  .reg_addr (reg_addr),
  .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata),
  .mode     (mode),
  .cyc_timer(cyc_timer),
  .ts_out   (ts_out)
);

// File: tb/sim_ts_offset_adder.sv
module sim_ts_offset_adder;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [2:0]  ctx;
    logic [1:0]  md;
    logic        init;
    logic [6:0]  sec;
    logic [12:0] cnt;
    logic [11:0] ofs;
    logic [12:0] ecnt;
    logic [11:0] eofs;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{3'd0, 2'd1, 1'b0, 7'd5,   13'd10,   12'd20,   13'd110,  12'd220},   // R5
    '{3'd0, 2'd2, 1'b1, 7'd0,   13'd7900, 12'd2900, 13'd1,    12'd28},    // R7, R9 flag clear
    '{3'd1, 2'd1, 1'b1, 7'd0,   13'd0,    12'd0,    13'd7999, 12'd3071},  // R8
    '{3'd1, 2'd2, 1'b1, 7'd0,   13'd1234, 12'd567,  13'd1234, 12'd567},   // R9 suppressed
    '{3'd1, 2'd2, 1'b0, 7'd0,   13'd1,    12'd1,    13'd1,    12'd0},     // R7, R9 later packet
    '{3'd2, 2'd1, 1'b0, 7'd0,   13'd7994, 12'd71,   13'd7999, 12'd3071},  // R5 just below
    '{3'd2, 2'd1, 1'b0, 7'd0,   13'd7994, 12'd72,   13'd0,    12'd0},     // R7 exact
    '{3'd7, 2'd0, 1'b0, 7'd0,   13'd3,    12'd4,    13'd3,    12'd4},     // R4
    '{3'd7, 2'd3, 1'b1, 7'd9,   13'd7000, 12'd3000, 13'd7000, 12'd3000},  // R4
    '{3'd7, 2'd2, 1'b0, 7'd0,   13'd3999, 12'd2071, 13'd7999, 12'd3071},  // R6 below
    '{3'd7, 2'd2, 1'b0, 7'd0,   13'd4000, 12'd100,  13'd0,    12'd1100},  // R6 wrap
    '{3'd3, 2'd1, 1'b0, 7'd0,   13'd55,   12'd66,   13'd55,   12'd66},    // R10 ctx3 zero
    '{3'd0, 2'd1, 1'b0, 7'd127, 13'd0,    12'd3000, 13'd101,  12'd128},   // R11
    '{3'd2, 2'd2, 1'b0, 7'd0,   13'd0,    12'd0,    13'd5,    12'd3000},  // R9 later packet
    '{3'd2, 2'd2, 1'b1, 7'd0,   13'd10,   12'd10,   13'd10,   12'd10}     // R9 suppressed
  };

  logic        clk;
  logic        rst_n;
  logic        reg_we;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [2:0]  ctx_sel;
  logic [1:0]  mode;
  logic        init_pkt;
  logic [31:0] cyc_timer;
  logic [24:0] ts_out;

  int n_chk;
  int n_err;
  bit done;

  ts_offset_adder u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ctx_sel(ctx_sel),
    .mode(mode), .init_pkt(init_pkt), .cyc_timer(cyc_timer), .ts_out(ts_out)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] mkw(input logic skip, input int c, input int o);
    return {skip, 6'b0, 13'(c), 12'(o)};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 3'(idx); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_chk(input string req, input int idx, input logic [31:0] exp);
    @(negedge clk);
    reg_addr = 3'(idx);
    #1;
    check(req, reg_rdata, exp);
  endtask

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    ctx_sel = '0; mode = 2'd0; init_pkt = 1'b0; cyc_timer = '0;
    n_chk = 0; n_err = 0; done = 1'b0;

    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 ts_out", 32'(ts_out), 32'h0);
    for (int i = 0; i < 8; i++) rd_chk("R1 reg", i, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    // R2: program contexts
    wr(0, mkw(1'b0, 100, 200));
    wr(1, mkw(1'b1, 7999, 3071));
    wr(2, mkw(1'b1, 5, 3000));
    wr(7, mkw(1'b0, 4000, 1000));
    wr(6, mkw(1'b1, 1, 2));
    rd_chk("R2 ctx0", 0, mkw(1'b0, 100, 200));
    rd_chk("R2 ctx1", 1, mkw(1'b1, 7999, 3071));
    rd_chk("R2 ctx2", 2, mkw(1'b1, 5, 3000));
    rd_chk("R2 ctx3 untouched", 3, 32'h0);
    rd_chk("R2 ctx6", 6, mkw(1'b1, 1, 2));
    rd_chk("R2 ctx7", 7, mkw(1'b0, 4000, 1000));

    // R3: reserved bits
    wr(4, 32'hFFFF_FFFF);
    rd_chk("R3 all ones", 4, 32'h81FF_FFFF);
    wr(5, 32'h7E00_0000);
    rd_chk("R3 rsv only", 5, 32'h0);

    // vector table
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      ctx_sel   = VEC[v].ctx;
      mode      = VEC[v].md;
      init_pkt  = VEC[v].init;
      cyc_timer = {VEC[v].sec, VEC[v].cnt, VEC[v].ofs};
      @(negedge clk);
      check($sformatf("R4-R11 vec%0d", v), 32'(ts_out), 32'({VEC[v].ecnt, VEC[v].eofs}));
    end

    // R10: one-cycle latency
    begin
      logic [24:0] prev;
      @(negedge clk);
      prev      = ts_out;
      ctx_sel   = 3'd0; mode = 2'd1; init_pkt = 1'b0;
      cyc_timer = {7'd0, 13'd10, 12'd20};
      #(CLK_PERIOD/2 - 1);
      check("R10 before edge", 32'(ts_out), 32'(prev));
      @(negedge clk);
      check("R10 after edge", 32'(ts_out), 32'({13'd110, 12'd220}));
    end

    // R8: DV with init strobe on flagged ctx2
    @(negedge clk);
    ctx_sel = 3'd2; mode = 2'd1; init_pkt = 1'b1;
    cyc_timer = {7'd3, 13'd20, 12'd30};
    @(negedge clk);
    check("R8 dv ignores flag", 32'(ts_out), 32'({13'd25, 12'd3030}));

    // R1: reset mid-run
    @(negedge clk);
    mode = 2'd0; init_pkt = 1'b0; ctx_sel = 3'd0;
    rst_n = 1'b0;
    #1;
    check("R1 ts_out mid reset", 32'(ts_out), 32'h0);
    rd_chk("R1 ctx6 mid reset", 6, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule